// File: doc/BRIEF.md
# Chained Servo Pulse Sequencer

This block drives six hobby-servo outputs from six 16-bit width registers, each holding a pulse length in microseconds. Once per frame it plays the channels back to back: output 0 goes high for its width, and in the clock cycle it drops, output 1 rises, and so on up to output 5. After the last pulse every output stays low until the next frame. The frame repeats every `FRAME_US` ticks (20 ms at the default), built as every second wrap of a half-frame (10 ms) counter. A single-cycle `tick_us` enable marks each microsecond; all timing counts that enable, not clock cycles.

A host loads a new width by presenting a channel number and a full 16-bit value for one cycle, so a width can never be half old and half new. Each slot copies its width into a private countdown at the moment the slot begins. A write therefore affects the current frame only if it lands before that channel's slot starts. With `ppm_en` high, output 5 stops carrying its own servo pulse. It instead carries a composite stream: a fixed `MARK_US` marker (400 µs at the default) is launched at the start of every channel slot. The marker has its own timer.

Top module: `servo_train`

## Requirements
- R1: During and after reset all outputs are low, and every width register holds `RESET_WIDTH` (default 1500).
- R2: A frame starts every `FRAME_US` ticks of `tick_us` (every second wrap of a `FRAME_US/2` half-frame counter), and each frame starts at channel 0.
- R3: Channels run in index order 0 to 5 (output bit k is channel k), and channel k+1 rises in the same clock cycle that channel k falls; at most one of the sequenced pulses is high at a time.
- R4: A channel with width W > 0 is high for exactly W ticks of `tick_us`. No time passes without a tick, and all outputs are low from the end of channel 5 until the next frame.
- R5: A width of 0 gives no high time on that output, but its slot still uses one tick, so the following channel rises one tick after the previous one falls.
- R6: With `wr_en` high for one cycle, `wr_data` (16 bits) fully replaces the register selected by `wr_sel` (values 0 to 5). A `wr_sel` of 6 or 7 changes no register.
- R7: A channel uses the width its register holds just before its slot starts. A write landing in the cycle the slot starts, or later, takes effect in the next frame. A write that lands earlier in the same frame applies in that frame.
- R8: With `ppm_en` high, output 5 goes high for `MARK_US` ticks starting at the start of each of the six slots, and channel 5's own pulse is not shown.
- R9: The marker timer restarts at every slot start, independent of the slot timer. Markers launched by slots shorter than `MARK_US` merge into one high run, and output 5 falls exactly `MARK_US` ticks after the last slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle enable per microsecond |
| ppm_en | input | 1 | Output 5 carries the composite marker stream |
| wr_en | input | 1 | Write strobe for a width register |
| wr_sel | input | 3 | Channel selected by the write (0 to 5 valid) |
| wr_data | input | 16 | New width in microseconds |
| servo_o | output | 6 | Servo outputs, bit k is channel k |

## Verification
A host write and a slot start can fall in the same clock cycle. The register then updates on the same edge at which the countdown copies it. The bench counts cycles from the observed frame start and places a write exactly on the slot-start edge of channel 3. It places further writes one cycle later, for channel 4, and for a channel already finished, channel 0. It then checks that channel 3 keeps its old width in this frame, that channel 4 takes its new width at once, and that channels 0 and 3 show their new widths only in the following frame. A second coincidence, a marker relaunch while the previous marker is still high, is judged by the rise count and final fall time of output 5.

// File: rtl/servo_pkg.sv
package servo_pkg;

    // Which half of the frame the half-frame counter is currently in.
    typedef enum logic {
        HALF_FIRST  = 1'b0,
        HALF_SECOND = 1'b1
    } half_e;

endpackage

// File: rtl/servo_width_bank.sv
module servo_width_bank #(
    parameter  int NUM_CH      = 6,
    parameter  int WIDTH_W     = 16,
    parameter  int RESET_WIDTH = 1500,
    localparam int SEL_W       = $clog2(NUM_CH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [WIDTH_W-1:0] wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [WIDTH_W-1:0] rd_width
);

    localparam logic [SEL_W-1:0] NUM_SEL = SEL_W'(NUM_CH);

    logic [WIDTH_W-1:0] width_q [NUM_CH];
    logic [WIDTH_W-1:0] width_d [NUM_CH];

    // Whole-word replacement in one cycle: no partial value ever exists.
    always_comb begin
        width_d = width_q;
        if (wr_en && (wr_sel < NUM_SEL)) begin
            width_d[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                width_q[i] <= WIDTH_W'(RESET_WIDTH);
            end
        end else begin
            width_q <= width_d;
        end
    end

    assign rd_width = (rd_sel < NUM_SEL) ? width_q[rd_sel] : '0;

    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel < NUM_SEL)) |=> (width_q[$past(wr_sel)] == $past(wr_data)));

endmodule

// File: rtl/servo_frame_seq.sv
module servo_frame_seq
    import servo_pkg::*;
#(
    parameter  int NUM_CH   = 6,
    parameter  int WIDTH_W  = 16,
    parameter  int FRAME_US = 20000,
    localparam int HALF_US  = FRAME_US / 2,
    localparam int HC_W     = $clog2(HALF_US),
    localparam int SEL_W    = $clog2(NUM_CH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic [WIDTH_W-1:0] slot_width,
    output logic [SEL_W-1:0]   next_sel,
    output logic               slot_start,
    output logic [NUM_CH-1:0]  pulse_o
);

    localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(NUM_CH - 1);
    localparam logic [HC_W-1:0]  HALF_LAST = HC_W'(HALF_US - 1);

    typedef struct packed {
        logic [HC_W-1:0]    half_cnt;
        half_e              half;
        logic               active;
        logic [SEL_W-1:0]   slot;
        logic [WIDTH_W-1:0] remain;
    } seq_t;

    seq_t seq_q, seq_d;
    logic frame_start;

    always_comb begin
        frame_start = tick_us && (seq_q.half_cnt == HALF_LAST)
                      && (seq_q.half == HALF_SECOND);
        next_sel    = frame_start ? '0 : seq_q.slot + 1'b1;
        seq_d       = seq_q;
        slot_start  = 1'b0;
        if (tick_us) begin
            if (seq_q.half_cnt == HALF_LAST) begin
                seq_d.half_cnt = '0;
                seq_d.half     = (seq_q.half == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
            end else begin
                seq_d.half_cnt = seq_q.half_cnt + 1'b1;
            end
            if (frame_start) begin
                seq_d.active = 1'b1;
                seq_d.slot   = '0;
                seq_d.remain = slot_width;
                slot_start   = 1'b1;
            end else if (seq_q.active) begin
                if (seq_q.remain <= WIDTH_W'(1)) begin
                    if (seq_q.slot == LAST_SLOT) begin
                        seq_d.active = 1'b0;
                        seq_d.remain = '0;
                    end else begin
                        seq_d.slot   = seq_q.slot + 1'b1;
                        seq_d.remain = slot_width;
                        slot_start   = 1'b1;
                    end
                end else begin
                    seq_d.remain = seq_q.remain - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{half_cnt: '0, half: HALF_FIRST, active: 1'b0, slot: '0, remain: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pulse
        assign pulse_o[ch] = seq_q.active && (seq_q.slot == SEL_W'(ch))
                             && (seq_q.remain != '0);
    end

    assert_frame_opens_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (seq_q.active && (seq_q.slot == '0)));

    assert_no_tick_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_us |=> $stable(seq_q.remain) && $stable(seq_q.slot));

endmodule

// File: rtl/servo_ppm_marker.sv
module servo_ppm_marker #(
    parameter  int MARK_US = 400,
    localparam int MARK_W  = $clog2(MARK_US + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic ppm_en,
    input  logic launch,
    output logic mark_o
);

    localparam logic [MARK_W-1:0] MARK_LOAD = MARK_W'(MARK_US);

    logic [MARK_W-1:0] cnt_q, cnt_d;

    // Own countdown: keeps running across slot boundaries, relaunched per slot.
    always_comb begin
        cnt_d = cnt_q;
        if (!ppm_en) begin
            cnt_d = '0;
        end else if (launch) begin
            cnt_d = MARK_LOAD;
        end else if (tick_us && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign mark_o = (cnt_q != '0);

    assert_marker_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MARK_LOAD);

    assert_marker_relaunch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ppm_en && launch) |=> (cnt_q == MARK_LOAD));

endmodule

// File: rtl/servo_train.sv
module servo_train #(
    parameter  int NUM_CH      = 6,
    parameter  int WIDTH_W     = 16,
    parameter  int FRAME_US    = 20000,
    parameter  int MARK_US     = 400,
    parameter  int RESET_WIDTH = 1500,
    localparam int SEL_W       = $clog2(NUM_CH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_us,
    input  logic               ppm_en,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [WIDTH_W-1:0] wr_data,
    output logic [NUM_CH-1:0]  servo_o
);

    logic [SEL_W-1:0]   next_sel;
    logic [WIDTH_W-1:0] slot_width;
    logic               slot_start;
    logic [NUM_CH-1:0]  pulse;
    logic               marker;

    servo_width_bank #(
        .NUM_CH(NUM_CH), .WIDTH_W(WIDTH_W), .RESET_WIDTH(RESET_WIDTH)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(next_sel), .rd_width(slot_width)
    );

    servo_frame_seq #(
        .NUM_CH(NUM_CH), .WIDTH_W(WIDTH_W), .FRAME_US(FRAME_US)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .slot_width(slot_width),
        .next_sel(next_sel), .slot_start(slot_start), .pulse_o(pulse)
    );

    servo_ppm_marker #(
        .MARK_US(MARK_US)
    ) u_mark (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ppm_en(ppm_en),
        .launch(slot_start), .mark_o(marker)
    );

    always_comb begin
        servo_o = pulse;
        if (ppm_en) begin
            servo_o[NUM_CH-1] = marker;
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));

    assert_marker_at_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ppm_en && slot_start) |=> (!ppm_en || servo_o[NUM_CH-1]));

endmodule

// File: tb/tb_servo_train.sv
module tb_servo_train;

    localparam int N     = 6;
    localparam int FRAME = 2000;
    localparam int MARK  = 40;
    localparam int RSTW  = 100;
    localparam int SETTLE = 1200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        ppm_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [N-1:0] servo_o;

    int total = 0;
    int bad = 0;
    int tick_div = 1;
    int tphase = 0;
    int cyc = 0;
    int rise_c[N], fall_c[N], hi[N], nrise[N];
    logic [N-1:0] prev = '0;
    int wexp[N];

    always #2 clk = ~clk;

    servo_train #(
        .NUM_CH(N), .WIDTH_W(16), .FRAME_US(FRAME), .MARK_US(MARK), .RESET_WIDTH(RSTW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ppm_en(ppm_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .servo_o(servo_o)
    );

    // Tick generator: one tick every tick_div cycles.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tphase = (tphase + 1) % tick_div;
            tick_us = (tphase == 0);
        end
    end

    // Output monitor, sampled mid-cycle.
    initial begin
        for (int k = 0; k < N; k++) begin
            rise_c[k] = 0; fall_c[k] = 0; hi[k] = 0; nrise[k] = 0;
        end
        forever begin
            @(negedge clk);
            cyc++;
            for (int k = 0; k < N; k++) begin
                if (servo_o[k] && !prev[k]) begin
                    rise_c[k] = cyc; hi[k] = 0; nrise[k]++;
                end
                if (servo_o[k]) hi[k] += int'(tick_us);
                if (!servo_o[k] && prev[k]) fall_c[k] = cyc;
            end
            prev = servo_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int slot_offset(input int k);
        int s = 0;
        for (int j = 0; j < k; j++) s += (wexp[j] == 0) ? 1 : wexp[j];
        return s;
    endfunction

    task automatic write_w(input int sel, input int val);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(val);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        int b = nrise[0];
        while (nrise[0] == b) begin
            @(negedge clk); #1;
        end
    endtask

    // mode 0: plain frame; mode 1: writes placed against slot starts
    task automatic run_frame(input int mode, input bit fast, output int base[N]);
        for (int k = 0; k < N; k++) base[k] = nrise[k];
        wait_start();
        base[0] = base[0];
        if (mode == 1) begin
            repeat (149) @(posedge clk);
            #1 wr_en = 1'b1; wr_sel = 3'd3; wr_data = 16'd90;
            @(posedge clk); #1 wr_sel = 3'd4; wr_data = 16'd80;
            @(posedge clk); #1 wr_sel = 3'd0; wr_data = 16'd70;
            @(posedge clk); #1 wr_en = 1'b0;
        end
        repeat (fast ? SETTLE : SETTLE * tick_div) @(posedge clk);
        @(negedge clk); #1;
    endtask

    task automatic check_frame(input string tag, input bit fast, input int base[N]);
        for (int k = 0; k < N; k++) begin
            if (wexp[k] == 0) begin
                chk("R5", {tag, " zero width no pulse"}, nrise[k] - base[k], 0);
            end else begin
                chk("R4", {tag, " pulse width ticks"}, hi[k], wexp[k]);
                chk("R4", {tag, " one pulse per frame"}, nrise[k] - base[k], 1);
            end
        end
        if (fast) begin
            for (int k = 1; k < N; k++) begin
                if (wexp[k] != 0) begin
                    chk("R3", {tag, " slot start offset"}, rise_c[k] - rise_c[0], slot_offset(k));
                    if (wexp[k-1] != 0)
                        chk("R3", {tag, " handoff same cycle"}, rise_c[k], fall_c[k-1]);
                    else if (k >= 2 && wexp[k-2] != 0)
                        chk("R5", {tag, " zero slot takes one tick"}, rise_c[k] - fall_c[k-2], 1);
                end
            end
        end
    endtask

    initial begin
        int base[N];
        int r_prev;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "outputs low in reset", int'(servo_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R1", "outputs low after reset", int'(servo_o), 0);

        // R1/R3/R4: first frame carries reset widths
        for (int k = 0; k < N; k++) wexp[k] = RSTW;
        run_frame(0, 1'b1, base);
        check_frame("reset widths R1", 1'b1, base);
        r_prev = rise_c[0];

        // R2: frame period in ticks
        run_frame(0, 1'b1, base);
        chk("R2", "frame period", rise_c[0] - r_prev, FRAME);

        // Random widths with occasional zeros
        for (int f = 0; f < 3; f++) begin
            for (int k = 0; k < N; k++) begin
                if (k == 0) wexp[k] = 1 + int'($urandom % 150);
                else wexp[k] = ($urandom % 4 == 0) ? 0 : 1 + int'($urandom % 150);
                write_w(k, wexp[k]);
            end
            run_frame(0, 1'b1, base);
            check_frame("random R4", 1'b1, base);
        end

        // R5: directed zero in the middle and at the last slot
        wexp = '{120, 30, 0, 45, 0, 0};
        for (int k = 0; k < N; k++) write_w(k, wexp[k]);
        run_frame(0, 1'b1, base);
        check_frame("zero slots R5", 1'b1, base);
        chk("R4", "idle after last pulse", int'(servo_o), 0);

        // R6: out-of-range selects are ignored
        write_w(6, 7);
        write_w(7, 9);
        run_frame(0, 1'b1, base);
        check_frame("ignored select R6", 1'b1, base);

        // R7: writes against slot starts
        wexp = '{50, 50, 50, 50, 50, 50};
        for (int k = 0; k < N; k++) write_w(k, wexp[k]);
        run_frame(0, 1'b1, base);
        run_frame(1, 1'b1, base);
        wexp[4] = 80;
        check_frame("same-cycle write R7", 1'b1, base);
        wexp[0] = 70; wexp[3] = 90;
        run_frame(0, 1'b1, base);
        check_frame("deferred write R7", 1'b1, base);

        // R4: slow tick, widths counted in ticks
        wexp = '{33, 17, 25, 5, 40, 12};
        for (int k = 0; k < N; k++) write_w(k, wexp[k]);
        tick_div = 3;
        run_frame(0, 1'b0, base);
        check_frame("slow tick R4", 1'b0, base);
        tick_div = 1;

        // R8/R9: composite marker stream with one short slot
        wexp = '{60, 60, 60, 10, 60, 60};
        for (int k = 0; k < N; k++) write_w(k, wexp[k]);
        ppm_en = 1'b1;
        run_frame(0, 1'b1, base);
        for (int k = 0; k < N - 1; k++)
            chk("R8", "servo widths in marker mode", hi[k], wexp[k]);
        chk("R9", "merged marker rises", nrise[N-1] - base[N-1], 5);
        chk("R8", "last marker length", hi[N-1], MARK);
        chk("R8", "marker at last slot start", rise_c[N-1], fall_c[N-2]);
        chk("R9", "marker ends after last start", fall_c[N-1] - fall_c[N-2], MARK);
        ppm_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule